// File: doc/BRIEF.md
# Valid-Pixel Capture Writer

This block sits between a digital camera's parallel output and a frame memory with one port. The camera sends a 12-bit pixel word, a pixel strobe that never stops toggling, a frame-valid level and a line-valid level. The block brings each of these into its own clock domain through a short synchroniser chain. It then finds the falling edges of the strobe. A pixel is written to memory only when frame-valid and line-valid were both high at that edge. Strobe periods in the blanking between lines, and the periods before and after a frame, leave the memory and the address untouched.

The host arms the block with a one-cycle pulse. Capture then waits for the next rising edge of frame-valid, so a frame that is already streaming when the arm comes in is skipped as a whole. Each captured pixel takes the next address from a linear counter that starts at zero. With the default width this counter spans a 1024 by 1024 image. When frame-valid falls, the block ends the capture and gives a one-cycle completion pulse. Once the last location has been written, the counter holds. Any later valid pixel is dropped and sets a sticky overflow flag. A synchronous clear input sets the counter back to zero and removes the overflow.

Top module: `pixel_capture`

## Requirements
- R1: A memory write happens once for each falling edge of the pixel strobe at which frame-valid and line-valid are both high. The written word equals the pixel value the camera held across that falling edge.
- R2: Strobe falling edges with frame-valid low or line-valid low produce no write and do not advance the address.
- R3: Within a capture, successive writes use successive addresses, each one higher than the last, with no holes at line gaps.
- R4: A pulse on `addr_clr` makes the next write land at address 0 and clears `overflow` on the following clock.
- R5: After an `arm` pulse, capture starts at the next rising edge of frame-valid. A frame whose frame-valid was already high when `arm` came in produces no writes.
- R6: When frame-valid falls at the end of a captured frame, `frame_done` is high for exactly one clock. Capture then stops, so a later frame with no new `arm` produces no writes and no `frame_done`. A skipped frame produces no `frame_done`.
- R7: Once the highest address (all ones across ADDR_W bits) has been written, the counter holds. Later valid pixels are not written, and `overflow` goes high and stays high until `addr_clr`.
- R8: After reset, `mem_we`, `frame_done` and `overflow` are low and `mem_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | capture clock |
| rst_n | input | 1 | active-low synchronous reset |
| addr_clr | input | 1 | synchronous clear of the write address and the overflow flag |
| arm | input | 1 | host pulse that enables capture of the next frame |
| cam_data | input | PIX_W | camera pixel word |
| cam_strobe | input | 1 | free-running camera pixel strobe |
| cam_fval | input | 1 | camera frame-valid |
| cam_lval | input | 1 | camera line-valid |
| mem_we | output | 1 | one-cycle write strobe to the frame memory |
| mem_addr | output | ADDR_W | write address |
| mem_wdata | output | PIX_W | write data |
| frame_done | output | 1 | one-cycle pulse at the end of a captured frame |
| overflow | output | 1 | sticky flag: a valid pixel arrived after the memory was full |

## Verification
The assertions assume three things about the inputs. The strobe stays at each level for at least two capture clocks. `addr_clr` is raised only while no pixels are arriving. Pixel, frame-valid and line-valid change only at strobe rising edges. The camera model in the bench holds each strobe level for two clocks and changes all camera inputs together with the strobe rise. It also pulses the clear only after a frame has drained. Under these conditions the address-step and single-pulse properties are well defined.

// File: rtl/pixel_capture.sv
module pixel_capture #(
  parameter int PIX_W       = 12,
  parameter int ADDR_W      = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_clr,
  input  logic              arm,
  input  logic [PIX_W-1:0]  cam_data,
  input  logic              cam_strobe,
  input  logic              cam_fval,
  input  logic              cam_lval,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  output logic              frame_done,
  output logic              overflow
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  logic [SYNC_STAGES-1:0] strb_sh, fval_sh, lval_sh;
  logic [PIX_W-1:0]       dat_sh [SYNC_STAGES];
  logic                   strb_d, fval_d;
  logic                   armed, active, full;
  logic [ADDR_W-1:0]      addr;

  wire strb_s  = strb_sh[SYNC_STAGES-1];
  wire fval_s  = fval_sh[SYNC_STAGES-1];
  wire lval_s  = lval_sh[SYNC_STAGES-1];
  wire strb_fl = strb_d & ~strb_s;
  wire fv_rise = fval_s & ~fval_d;
  wire fv_fall = fval_d & ~fval_s;
  wire start   = armed & fv_rise;
  wire take    = strb_fl & fval_s & lval_s & (active | start);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_sh <= '0; fval_sh <= '0; lval_sh <= '0;
      for (int i = 0; i < SYNC_STAGES; i++) dat_sh[i] <= '0;
      strb_d <= 1'b0; fval_d <= 1'b0;
      armed <= 1'b0; active <= 1'b0; full <= 1'b0;
      addr <= '0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      frame_done <= 1'b0; overflow <= 1'b0;
    end else begin
      strb_sh <= {strb_sh[SYNC_STAGES-2:0], cam_strobe};
      fval_sh <= {fval_sh[SYNC_STAGES-2:0], cam_fval};
      lval_sh <= {lval_sh[SYNC_STAGES-2:0], cam_lval};
      dat_sh[0] <= cam_data;
      for (int i = 1; i < SYNC_STAGES; i++) dat_sh[i] <= dat_sh[i-1];
      strb_d <= strb_s;
      fval_d <= fval_s;
      mem_we <= 1'b0;
      frame_done <= 1'b0;
      if (arm && !active) armed <= 1'b1;
      if (start) begin
        active <= 1'b1;
        armed  <= 1'b0;
      end
      if (fv_fall && active) begin
        active     <= 1'b0;
        frame_done <= 1'b1;
      end
      if (take) begin
        if (full) overflow <= 1'b1;
        else begin
          mem_we    <= 1'b1;
          mem_addr  <= addr;
          mem_wdata <= dat_sh[SYNC_STAGES-1];
          if (addr == ADDR_MAX) full <= 1'b1;
          else addr <= addr + 1'b1;
        end
      end
      if (addr_clr) begin
        addr     <= '0;
        full     <= 1'b0;
        overflow <= 1'b0;
      end
    end
  end
endmodule

module pixel_capture_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_clr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              frame_done,
  input logic              overflow,
  input logic              full
);
  logic [ADDR_W-1:0] last_addr;
  logic              have_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_addr <= '0;
      have_last <= 1'b0;
    end else if (addr_clr) begin
      have_last <= 1'b0;
    end else if (mem_we) begin
      last_addr <= mem_addr;
      have_last <= 1'b1;
    end
  end

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && have_last) |-> (mem_addr == last_addr + 1'b1));
  assert_first_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !have_last) |-> (mem_addr == '0));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(full));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !addr_clr) |=> overflow);
  assert_we_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
endmodule

bind pixel_capture pixel_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_clr(addr_clr), .mem_we(mem_we),
  .mem_addr(mem_addr), .frame_done(frame_done), .overflow(overflow), .full(full)
);

// File: tb/tb_pixel_capture.sv
module tb_pixel_capture;
  localparam int PERIOD = 10;
  localparam int PIX_W  = 12;
  localparam int ADDR_W = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NVEC   = 4;
  localparam int VEC [NVEC][4] = '{
    '{2, 4, 3, 17}, '{3, 5, 1, 300}, '{1, 8, 6, 4000}, '{4, 3, 2, 1234}
  };

  logic clk = 0, rst_n = 0, addr_clr = 0, arm = 0;
  logic [PIX_W-1:0] cam_data = '0;
  logic cam_strobe = 0, cam_fval = 0, cam_lval = 0;
  logic mem_we, frame_done, overflow;
  logic [ADDR_W-1:0] mem_addr;
  logic [PIX_W-1:0] mem_wdata;

  always #(PERIOD/2) clk = ~clk;

  pixel_capture #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .addr_clr(addr_clr), .arm(arm),
    .cam_data(cam_data), .cam_strobe(cam_strobe), .cam_fval(cam_fval),
    .cam_lval(cam_lval), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .frame_done(frame_done), .overflow(overflow)
  );

  int total = 0, bad = 0;
  int exp_addr [256];
  int exp_data [256];
  int wr = 0, rd = 0, done_cnt = 0, exp_next = 0;
  bit capture_on = 0, finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && frame_done) done_cnt++;
    if (rst_n && mem_we) begin
      if (rd >= wr) chk(0, "R2 unexpected write", int'(mem_addr), -1);
      else begin
        chk(int'(mem_addr) == exp_addr[rd], "R3 write address", int'(mem_addr), exp_addr[rd]);
        chk(int'(mem_wdata) == exp_data[rd], "R1 write data", int'(mem_wdata), exp_data[rd]);
        rd++;
      end
    end
  end

  task automatic pixel(input bit fv, input bit lv, input int d);
    @(negedge clk);
    cam_strobe = 1; cam_fval = fv; cam_lval = lv; cam_data = PIX_W'(d);
    if (fv && lv && capture_on && exp_next < DEPTH) begin
      exp_addr[wr] = exp_next; exp_data[wr] = d & 12'hFFF; wr++;
      exp_next++;
    end
    @(negedge clk);
    @(negedge clk);
    cam_strobe = 0;
    @(negedge clk);
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); addr_clr = 1; @(negedge clk); addr_clr = 0;
    exp_next = 0;
  endtask

  task automatic run_frame(input int lines, input int ppl, input int gap, input int seed, input bit arm_mid);
    int cnt = 0;
    repeat (3) pixel(0, 1, seed ^ 12'hABC);
    repeat (2) pixel(1, 0, seed ^ 12'h555);
    for (int l = 0; l < lines; l++) begin
      if (arm_mid && l == 1) pulse_arm();
      for (int p = 0; p < ppl; p++) begin
        pixel(1, 1, (seed + cnt * 7) & 12'hFFF);
        cnt++;
      end
      for (int g = 0; g < gap; g++) pixel(1, 0, 12'hFFF - g);
    end
    repeat (3) pixel(0, 0, 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    chk(0, "watchdog", 0, 1);
    if (!finished) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d0;
    repeat (4) @(negedge clk);
    chk(mem_we == 0, "R8 we after reset", int'(mem_we), 0);
    chk(mem_addr == 0, "R8 addr after reset", int'(mem_addr), 0);
    chk(frame_done == 0, "R8 done after reset", int'(frame_done), 0);
    chk(overflow == 0, "R8 overflow after reset", int'(overflow), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      pulse_clr();
      d0 = done_cnt;
      capture_on = 1;
      pulse_arm();
      run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 0);
      capture_on = 0;
      chk(rd == wr, "R1 all valid pixels written", rd, wr);
      chk(done_cnt == d0 + 1, "R6 one done pulse", done_cnt - d0, 1);
      chk(overflow == 0, "R7 no overflow in range", int'(overflow), 0);
    end

    // R2: strobes outside valid windows with capture armed
    pulse_clr();
    capture_on = 1;
    pulse_arm();
    repeat (4) pixel(0, 1, 77);
    repeat (4) pixel(0, 0, 78);
    repeat (8) @(negedge clk);
    chk(rd == wr, "R2 no write on invalid strobes", rd, wr);
    run_frame(1, 3, 2, 90, 0);
    capture_on = 0;
    chk(rd == wr && exp_addr[wr-1] == 2, "R2 address not advanced by invalid strobes", rd, wr);

    // R5: arm mid-frame ignored, next frame taken
    pulse_clr();
    d0 = done_cnt;
    capture_on = 0;
    run_frame(3, 4, 2, 500, 1);
    chk(rd == wr, "R5 in-progress frame skipped", rd, wr);
    chk(done_cnt == d0, "R6 no done for skipped frame", done_cnt - d0, 0);
    capture_on = 1;
    run_frame(2, 4, 2, 600, 0);
    capture_on = 0;
    chk(rd == wr && wr > 0 && exp_addr[wr-1] == 7, "R5 next frame captured from 0", rd, wr);
    chk(done_cnt == d0 + 1, "R6 done after captured frame", done_cnt - d0, 1);
    // R6: no capture without re-arm
    run_frame(2, 4, 2, 700, 0);
    chk(rd == wr, "R6 no capture without arm", rd, wr);
    chk(done_cnt == d0 + 1, "R6 no extra done", done_cnt - d0, 1);

    // R7: overflow
    pulse_clr();
    capture_on = 1;
    pulse_arm();
    run_frame(5, 8, 1, 900, 0);
    capture_on = 0;
    chk(rd == wr, "R7 writes stop at last address", rd, wr);
    chk(wr > 0 && exp_addr[wr-1] == DEPTH - 1, "R7 last address written", exp_addr[wr-1], DEPTH - 1);
    chk(overflow == 1, "R7 overflow set", int'(overflow), 1);
    repeat (5) @(negedge clk);
    chk(overflow == 1, "R7 overflow sticky", int'(overflow), 1);

    // R4: clear
    pulse_clr();
    @(negedge clk);
    chk(overflow == 0, "R4 overflow cleared", int'(overflow), 0);
    capture_on = 1;
    pulse_arm();
    run_frame(1, 4, 1, 1111, 0);
    capture_on = 0;
    chk(rd == wr && exp_addr[wr-4] == 0, "R4 restart at address 0", rd, wr);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule